// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the combinational arithmetic and logic unit of an 8-bit accumulator machine. Each evaluation takes the accumulator, a second operand, the current flag byte and a 5-bit operation code. It returns the new result, a strobe saying whether that result is to be written to its destination, and the new flag set. Five flags are kept: sign, zero, auxiliary (half) carry, parity and carry.

The operation set covers binary add and subtract, each with or without the carry or borrow chained in, compare, increment and decrement of the operand, AND, OR and XOR, accumulator complement, four rotates, set and invert carry, and a decimal correction step that follows a packed-BCD addition. Every operation has its own flag rule. Those rules are the main content of the block. Operand fetch, register selection and decode of the instruction stream are the job of the surrounding datapath.

The block holds no state, so the outputs follow the inputs within the same cycle.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0x00 (add) gives acc+opnd, and 0x01 (add-with-carry) gives acc+opnd+CY. CY is the carry out of bit 7 and AC is the carry out of bit 3. Both write. The flag vector is bit4=S, bit3=Z, bit2=AC, bit1=P, bit0=CY.
- R2: Opcode 0x02 (subtract) gives acc−opnd, and 0x03 (subtract-with-borrow) gives acc−opnd−CY. CY is 1 when the unsigned subtrahend (including the borrow) exceeds acc. AC is the borrow out of bit 3. Both write.
- R3: Opcode 0x04 (compare) sets all five flags exactly as subtract would. wr_en_o is 0 and res_o equals acc_i.
- R4: Opcodes 0x05 and 0x06 increment and decrement opnd_i and write the result. S, Z and P are updated. AC is the carry or borrow at bit 3. CY keeps its incoming value.
- R5: Opcode 0x07 (AND) writes acc&opnd with S, Z and P updated, CY forced to 0 and AC forced to 1.
- R6: Opcodes 0x08 (OR) and 0x09 (XOR) write acc|opnd and acc^opnd with S, Z and P updated and both CY and AC forced to 0.
- R7: Opcode 0x0A writes the bitwise inverse of acc and passes every flag through unchanged.
- R8: Opcode 0x0B (rotate left) copies bit 7 into bit 0 and into CY. Opcode 0x0C (rotate right) copies bit 0 into bit 7 and into CY. Both write, and the other flags pass through.
- R9: Opcode 0x0D (rotate left through carry) moves bit 7 into CY and the old CY into bit 0. Opcode 0x0E (rotate right through carry) moves bit 0 into CY and the old CY into bit 7. Both write, and the other flags pass through.
- R10: Opcode 0x0F sets CY to 1 and opcode 0x10 inverts CY. Neither writes, res_o equals acc_i, and the other flags pass through.
- R11: Opcode 0x11 (decimal adjust) adds 6 to the low nibble when that nibble exceeds 9 or AC is 1. It adds 6 to the high nibble when that nibble, plus any carry from the low correction, exceeds 9 or CY is 1. AC becomes the carry out of the low-nibble correction. CY is set by a carry out of bit 7 and is otherwise kept, never cleared.
- R12: Decimal adjust applied to 0xFF with all flags 0 gives 0x65 with CY=1. Applied to 0x16 with CY=1 it gives 0x76 with CY=1. Applied to 0x81 with AC=1 it gives 0x87 with CY=0.
- R13: Where an operation updates S, Z and P, S equals result bit 7, Z is 1 when the result is 0x00, and P is 1 when the result has an even count of 1 bits.
- R14: Opcodes 0x12 to 0x1F do nothing. wr_en_o is 0, res_o equals acc_i, and flag_o equals flag_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand (register, memory or immediate byte) |
| op_i | input | 5 | Operation code |
| flag_i | input | 5 | Current flags {S,Z,AC,P,CY} |
| res_o | output | 8 | Result value |
| wr_en_o | output | 1 | Write strobe for the destination |
| flag_o | output | 5 | Updated flags {S,Z,AC,P,CY} |

## Verification
Every result and flag is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench applies each vector just after a rising clock edge and compares all three outputs at the following falling edge, half a period later, once the logic has settled. Seeded random vectors over every opcode are checked against a bench model written from the requirements. Directed vectors cover the decimal-adjust worked cases, borrow at zero, increment wrap and the unused opcodes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'h00,
        OP_ADC = 5'h01,
        OP_SUB = 5'h02,
        OP_SBB = 5'h03,
        OP_CMP = 5'h04,
        OP_INC = 5'h05,
        OP_DEC = 5'h06,
        OP_AND = 5'h07,
        OP_OR  = 5'h08,
        OP_XOR = 5'h09,
        OP_CMA = 5'h0A,
        OP_RLC = 5'h0B,
        OP_RRC = 5'h0C,
        OP_RAL = 5'h0D,
        OP_RAR = 5'h0E,
        OP_STC = 5'h0F,
        OP_CMC = 5'h10,
        OP_DAA = 5'h11
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    typedef enum logic [1:0] {
        SRC_PASS,
        SRC_ARITH,
        SRC_LOGIC,
        SRC_DECADJ
    } res_src_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         ac_o
);
    localparam int H = W / 2;

    logic [W-1:0] y_eff;
    logic         c_eff;
    logic [W:0]   full;
    logic [H:0]   low;

    // subtraction as x + ~y + ~borrow; borrow out is the inverted carry
    always_comb begin
        y_eff = sub_i ? ~y_i : y_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        low   = {1'b0, x_i[H-1:0]} + {1'b0, y_eff[H-1:0]} + {{H{1'b0}}, c_eff};
        sum_o = full[W-1:0];
        cy_o  = full[W] ^ sub_i;
        ac_o  = low[H] ^ sub_i;
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        unique case (op_i)
            OP_AND: begin
                res_o = a_i & b_i;
                cy_o  = 1'b0;
            end
            OP_OR: begin
                res_o = a_i | b_i;
                cy_o  = 1'b0;
            end
            OP_XOR: begin
                res_o = a_i ^ b_i;
                cy_o  = 1'b0;
            end
            OP_CMA: res_o = ~a_i;
            OP_RLC: begin
                res_o = {a_i[W-2:0], a_i[W-1]};
                cy_o  = a_i[W-1];
            end
            OP_RRC: begin
                res_o = {a_i[0], a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_RAL: begin
                res_o = {a_i[W-2:0], cy_i};
                cy_o  = a_i[W-1];
            end
            OP_RAR: begin
                res_o = {cy_i, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            default: begin
                res_o = a_i;
                cy_o  = cy_i;
            end
        endcase
    end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic         cy_i,
    input  logic         ac_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o
);
    localparam int H = W / 2;
    localparam logic [H-1:0] NIB_SIX  = H'(6);
    localparam logic [H:0]   NIB_NINE = (H+1)'(9);

    logic         lo_fix;
    logic         hi_fix;
    logic [H:0]   lo_sum;
    logic [H:0]   hi_eff;
    logic [W-1:0] corr;
    logic [W:0]   total;

    always_comb begin
        lo_fix = ({1'b0, a_i[H-1:0]} > NIB_NINE) || ac_i;
        lo_sum = {1'b0, a_i[H-1:0]} + {1'b0, (lo_fix ? NIB_SIX : {H{1'b0}})};
        // high nibble judged after the low correction has rippled into it
        hi_eff = {1'b0, a_i[W-1:H]} + {{H{1'b0}}, lo_sum[H]};
        hi_fix = (hi_eff > NIB_NINE) || cy_i;
        corr   = {(hi_fix ? NIB_SIX : {H{1'b0}}), (lo_fix ? NIB_SIX : {H{1'b0}})};
        total  = {1'b0, a_i} + {1'b0, corr};
        res_o  = total[W-1:0];
        cy_o   = total[W] | cy_i;
        ac_o   = lo_sum[H];
    end

endmodule

// File: rtl/alu_szp.sv
module alu_szp
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] val_i,
    output logic         s_o,
    output logic         z_o,
    output logic         p_o
);
    logic [W-1:0] chain;

    // ripple parity chain, one stage per bit
    assign chain[0] = val_i[0];
    for (genvar k = 1; k < W; k++) begin : g_par
        assign chain[k] = chain[k-1] ^ val_i[k];
    end

    assign s_o = val_i[W-1];
    assign z_o = (val_i == '0);
    assign p_o = ~chain[W-1];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [FLAG_W-1:0] flag_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flag_o
);
    alu_op_e    op;
    alu_flags_t fin;
    alu_flags_t fout;
    res_src_e   src;

    logic [DATA_W-1:0] ar_x;
    logic [DATA_W-1:0] ar_y;
    logic              ar_cin;
    logic              ar_sub;
    logic [DATA_W-1:0] ar_sum;
    logic              ar_cy;
    logic              ar_ac;

    logic [DATA_W-1:0] lg_res;
    logic              lg_cy;

    logic [DATA_W-1:0] da_res;
    logic              da_cy;
    logic              da_ac;

    logic [DATA_W-1:0] res_sel;
    logic              szp_s;
    logic              szp_z;
    logic              szp_p;

    assign op  = alu_op_e'(op_i);
    assign fin = alu_flags_t'(flag_i);

    // operand steering for the shared adder
    always_comb begin
        src    = SRC_PASS;
        ar_x   = acc_i;
        ar_y   = opnd_i;
        ar_cin = 1'b0;
        ar_sub = 1'b0;
        unique case (op)
            OP_ADD: src = SRC_ARITH;
            OP_ADC: begin
                src    = SRC_ARITH;
                ar_cin = fin.cy;
            end
            OP_SUB, OP_CMP: begin
                src    = SRC_ARITH;
                ar_sub = 1'b1;
            end
            OP_SBB: begin
                src    = SRC_ARITH;
                ar_sub = 1'b1;
                ar_cin = fin.cy;
            end
            OP_INC: begin
                src    = SRC_ARITH;
                ar_x   = opnd_i;
                ar_y   = '0;
                ar_cin = 1'b1;
            end
            OP_DEC: begin
                src    = SRC_ARITH;
                ar_x   = opnd_i;
                ar_y   = '0;
                ar_cin = 1'b1;
                ar_sub = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CMA,
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: src = SRC_LOGIC;
            OP_DAA: src = SRC_DECADJ;
            default: src = SRC_PASS;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .x_i   (ar_x),
        .y_i   (ar_y),
        .cin_i (ar_cin),
        .sub_i (ar_sub),
        .sum_o (ar_sum),
        .cy_o  (ar_cy),
        .ac_o  (ar_ac)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cy_i  (fin.cy),
        .res_o (lg_res),
        .cy_o  (lg_cy)
    );

    alu_decadj #(.W(DATA_W)) u_decadj (
        .a_i   (acc_i),
        .cy_i  (fin.cy),
        .ac_i  (fin.ac),
        .res_o (da_res),
        .cy_o  (da_cy),
        .ac_o  (da_ac)
    );

    always_comb begin
        unique case (src)
            SRC_ARITH:  res_sel = ar_sum;
            SRC_LOGIC:  res_sel = lg_res;
            SRC_DECADJ: res_sel = da_res;
            default:    res_sel = acc_i;
        endcase
    end

    alu_szp #(.W(DATA_W)) u_szp (
        .val_i (res_sel),
        .s_o   (szp_s),
        .z_o   (szp_z),
        .p_o   (szp_p)
    );

    // per-operation flag rules and write strobe
    always_comb begin
        fout    = fin;
        wr_en_o = 1'b0;
        res_o   = acc_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
                fout    = '{s: szp_s, z: szp_z, ac: ar_ac, p: szp_p, cy: ar_cy};
            end
            OP_CMP: begin
                fout = '{s: szp_s, z: szp_z, ac: ar_ac, p: szp_p, cy: ar_cy};
            end
            OP_INC, OP_DEC: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
                fout    = '{s: szp_s, z: szp_z, ac: ar_ac, p: szp_p, cy: fin.cy};
            end
            OP_AND: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
                fout    = '{s: szp_s, z: szp_z, ac: 1'b1, p: szp_p, cy: lg_cy};
            end
            OP_OR, OP_XOR: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
                fout    = '{s: szp_s, z: szp_z, ac: 1'b0, p: szp_p, cy: lg_cy};
            end
            OP_CMA: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
                fout.cy = lg_cy;
            end
            OP_STC: fout.cy = 1'b1;
            OP_CMC: fout.cy = ~fin.cy;
            OP_DAA: begin
                wr_en_o = 1'b1;
                res_o   = res_sel;
                fout    = '{s: szp_s, z: szp_z, ac: da_ac, p: szp_p, cy: da_cy};
            end
            default: begin
                fout    = fin;
                wr_en_o = 1'b0;
                res_o   = acc_i;
            end
        endcase
    end

    assign flag_o = fout;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import alu_pkg::*;
(
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [OP_W-1:0]   op_i,
    input logic [FLAG_W-1:0] flag_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_en_o,
    input logic [FLAG_W-1:0] flag_o
);
    logic unused_opnd;
    assign unused_opnd = ^opnd_i;

    always_comb begin
        if (op_i == OP_CMP) begin
            a_r3_cmp_no_write: assert (!wr_en_o && res_o == acc_i);
        end
        if (op_i == OP_INC || op_i == OP_DEC) begin
            a_r4_incdec_keep_cy: assert (flag_o[0] == flag_i[0] && wr_en_o);
        end
        if (op_i == OP_AND) begin
            a_r5_and_forces: assert (flag_o[0] == 1'b0 && flag_o[2] == 1'b1);
        end
        if (op_i == OP_OR || op_i == OP_XOR) begin
            a_r6_orxor_clear: assert (flag_o[0] == 1'b0 && flag_o[2] == 1'b0);
        end
        if (op_i == OP_CMA) begin
            a_r7_cma_flags_hold: assert (flag_o == flag_i && res_o == ~acc_i);
        end
        if (op_i == OP_STC) begin
            a_r10_stc_sets: assert (flag_o[0] && flag_o[4:1] == flag_i[4:1] && !wr_en_o);
        end
        if (op_i == OP_DAA && flag_i[0]) begin
            a_r11_daa_cy_sticky: assert (flag_o[0]);
        end
        if (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_AND || op_i == OP_DAA) begin
            a_r13_zero_sign: assert (flag_o[3] == (res_o == '0) && flag_o[4] == res_o[DATA_W-1]);
        end
        if (op_i > OP_DAA) begin
            a_r14_idle_pass: assert (!wr_en_o && res_o == acc_i && flag_o == flag_i);
        end
    end

endmodule

bind acc_alu acc_alu_chk u_chk (
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .op_i    (op_i),
    .flag_i  (flag_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .flag_o  (flag_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    localparam real CLK_NS   = 8.0;
    localparam int  WATCHDOG = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [4:0] op_i = 5'h1F;
    logic [4:0] flag_i = '0;
    logic [7:0] res_o;
    logic       wr_en_o;
    logic [4:0] flag_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    acc_alu dut (
        .acc_i   (acc_i),
        .opnd_i  (opnd_i),
        .op_i    (op_i),
        .flag_i  (flag_i),
        .res_o   (res_o),
        .wr_en_o (wr_en_o),
        .flag_o  (flag_o)
    );

    function automatic logic [13:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [4:0] f);
        int t;
        int lo;
        int hi;
        int fix;
        logic [7:0] r;
        logic s, z, ac, p, cy, wr, upd;
        r = a; s = f[4]; z = f[3]; ac = f[2]; p = f[1]; cy = f[0];
        wr = 1'b0; upd = 1'b0;
        case (op)
            5'h00, 5'h01: begin
                t  = int'(a) + int'(b) + ((op == 5'h01) ? int'(f[0]) : 0);
                ac = ((int'(a[3:0]) + int'(b[3:0]) + ((op == 5'h01) ? int'(f[0]) : 0)) > 15);
                cy = (t > 255); r = t[7:0]; wr = 1'b1; upd = 1'b1;
            end
            5'h02, 5'h03, 5'h04: begin
                t  = int'(a) - int'(b) - ((op == 5'h03) ? int'(f[0]) : 0);
                ac = ((int'(a[3:0]) - int'(b[3:0]) - ((op == 5'h03) ? int'(f[0]) : 0)) < 0);
                cy = (t < 0); r = t[7:0]; wr = (op != 5'h04); upd = 1'b1;
            end
            5'h05: begin r = b + 8'd1; ac = (b[3:0] == 4'hF); wr = 1'b1; upd = 1'b1; end
            5'h06: begin r = b - 8'd1; ac = (b[3:0] == 4'h0); wr = 1'b1; upd = 1'b1; end
            5'h07: begin r = a & b; ac = 1'b1; cy = 1'b0; wr = 1'b1; upd = 1'b1; end
            5'h08: begin r = a | b; ac = 1'b0; cy = 1'b0; wr = 1'b1; upd = 1'b1; end
            5'h09: begin r = a ^ b; ac = 1'b0; cy = 1'b0; wr = 1'b1; upd = 1'b1; end
            5'h0A: begin r = ~a; wr = 1'b1; end
            5'h0B: begin r = {a[6:0], a[7]}; cy = a[7]; wr = 1'b1; end
            5'h0C: begin r = {a[0], a[7:1]}; cy = a[0]; wr = 1'b1; end
            5'h0D: begin r = {a[6:0], f[0]}; cy = a[7]; wr = 1'b1; end
            5'h0E: begin r = {f[0], a[7:1]}; cy = a[0]; wr = 1'b1; end
            5'h0F: cy = 1'b1;
            5'h10: cy = ~f[0];
            5'h11: begin
                lo = int'(a[3:0]); hi = int'(a[7:4]); fix = 0;
                if (lo > 9 || f[2]) begin fix = 6; lo = lo + 6; end
                ac = (lo > 15);
                if (hi + (lo > 15 ? 1 : 0) > 9 || f[0]) fix = fix + 96;
                t  = int'(a) + fix;
                cy = f[0] | (t > 255); r = t[7:0]; wr = 1'b1; upd = 1'b1;
            end
            default: ;
        endcase
        if (!wr && op != 5'h04 && op != 5'h0F && op != 5'h10) r = a;
        if (op == 5'h04 || op == 5'h0F || op == 5'h10) begin
            if (upd) begin
                s = r[7]; z = (r == 8'h00); p = ~(^r);
            end
            r = a;
        end else if (upd) begin
            s = r[7]; z = (r == 8'h00); p = ~(^r);
        end
        return {wr, r, s, z, ac, p, cy};
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'h00, 5'h01: return "R1";
            5'h02, 5'h03: return "R2";
            5'h04:        return "R3";
            5'h05, 5'h06: return "R4";
            5'h07:        return "R5";
            5'h08, 5'h09: return "R6";
            5'h0A:        return "R7";
            5'h0B, 5'h0C: return "R8";
            5'h0D, 5'h0E: return "R9";
            5'h0F, 5'h10: return "R10";
            5'h11:        return "R11";
            default:      return "R14";
        endcase
    endfunction

    task automatic apply(input string tag, input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [4:0] f);
        logic [13:0] exp_v;
        logic [13:0] got_v;
        @(posedge clk);
        #1;
        op_i = op; acc_i = a; opnd_i = b; flag_i = f;
        @(negedge clk);
        exp_v = model(op, a, b, f);
        got_v = {wr_en_o, res_o, flag_o};
        n_run++;
        if (got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h f=%b got wr=%b res=%h fl=%b exp wr=%b res=%h fl=%b",
                     tag, op, a, b, f, got_v[13], got_v[12:5], got_v[4:0],
                     exp_v[13], exp_v[12:5], exp_v[4:0]);
        end
    endtask

    task automatic expect_val(input string tag, input logic [7:0] got, input logic [7:0] exp_b);
        n_run++;
        if (got !== exp_b) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp_b);
        end
    endtask

    initial begin
        #(CLK_NS * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] rop;
        void'($urandom(32'h5EED_0A1C));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state after reset: unused opcode passes through (R14)
        apply("R14", 5'h1F, 8'h3C, 8'hA5, 5'b10101);

        // R12 worked decimal-adjust cases
        apply("R12", 5'h11, 8'hFF, 8'h00, 5'b00000);
        expect_val("R12", res_o, 8'h65);
        expect_val("R12", {7'd0, flag_o[0]}, 8'd1);
        apply("R12", 5'h11, 8'h16, 8'h00, 5'b00001);
        expect_val("R12", res_o, 8'h76);
        apply("R12", 5'h11, 8'h81, 8'h00, 5'b00100);
        expect_val("R12", res_o, 8'h87);
        expect_val("R12", {7'd0, flag_o[0]}, 8'd0);
        apply("R11", 5'h11, 8'h9A, 8'h00, 5'b00000);

        // R13 zero, sign and parity definitions
        apply("R13", 5'h02, 8'h55, 8'h55, 5'b00000);
        expect_val("R13", {3'd0, flag_o}, 8'b0000_1010);
        apply("R13", 5'h00, 8'h7F, 8'h01, 5'b00000);

        // borrow and wrap corners
        apply("R2", 5'h02, 8'h00, 8'h01, 5'b00000);
        apply("R2", 5'h03, 8'h05, 8'h05, 5'b00001);
        apply("R3", 5'h04, 8'h10, 8'h20, 5'b00000);
        apply("R4", 5'h05, 8'h00, 8'hFF, 5'b00001);
        apply("R4", 5'h06, 8'h00, 8'h00, 5'b00000);
        apply("R1", 5'h01, 8'hFF, 8'h00, 5'b00001);
        apply("R5", 5'h07, 8'hF0, 8'h0F, 5'b00001);
        apply("R9", 5'h0D, 8'h80, 8'h00, 5'b00001);
        apply("R9", 5'h0E, 8'h01, 8'h00, 5'b00000);
        apply("R10", 5'h10, 8'h12, 8'h00, 5'b11111);
        apply("R14", 5'h12, 8'hC3, 8'h77, 5'b01010);

        // seeded random sweep over every opcode
        for (int i = 0; i < 3000; i++) begin
            rop = 5'($urandom_range(0, 21));
            if (rop > 5'h13) rop = 5'($urandom_range(18, 31));
            apply(tag_of(rop), rop, 8'($urandom), 8'($urandom), 5'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule